// File: doc/BRIEF.md
# Scanline sprite pixel priority selector

This block sits at the end of a sprite pipeline in a tile-based video engine. For every pixel of a scanline it examines every sprite sliver that the line holds, and returns the colour index, palette and priority of the winning sprite pixel. It also returns a flag that tells the colour-math stage whether that pixel may take part in blending. A sliver is one row of an 8-pixel-wide sprite tile at 4 bits per pixel, placed at a horizontal start position.

Slot storage comes in two banks. The display bank feeds the comparators for the current line. The load bank takes writes for the next line. A one-cycle line-swap strobe, issued in horizontal blank, exchanges the two banks. All valid bits of the bank that has just left display are cleared, so only slots written again appear on the following line. The X coordinate goes in each cycle and the result comes out one cycle later.

Top module: `spr_line_select`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_color`, `out_pal`, `out_prio` and `out_cmath` are 0, and every slot in both banks is invalid.
- R2: The outputs are registered. The result for the `pix_x` present at one rising edge appears after that edge and is held until the next one.
- R3: A slot covers the positions where the offset (`pix_x` − start X) modulo 512 is 0 to 7. Pixel k of the sliver is `pattern[4k+3:4k]`, and pixel 0 sits at the start X. At any other offset the slot contributes nothing.
- R4: A pixel with colour index 0 is transparent. It never wins, and a lower-priority opaque pixel behind it shows through. `out_valid` is 1 only with a non-zero `out_color`.
- R5: Among the opaque candidate pixels, the one with the highest 2-bit priority is output (3 highest, 0 lowest).
- R6: When opaque candidates share the highest priority, the one in the lower slot index wins.
- R7: A write (`wr_en` high) stores palette, priority, start X and pattern into slot `wr_slot` of the load bank and marks it valid there. It does not change the output before the next `line_swap`.
- R8: On `line_swap` the banks exchange. Slots written since the previous swap are displayed, and a slot not written in that time is invalid on the new line. A swap with no writes before it gives an empty line.
- R9: `out_cmath` is 1 exactly when `out_valid` is 1 and `out_pal` is 4 to 7. It is 0 for palettes 0 to 3 and for no pixel. With no winner, colour, palette and priority read 0.
- R10: A write with `wr_slot` of 34 or more is ignored and changes no slot.
- R11: All 34 slots, indices 0 to 33, can be loaded and displayed.
- R12: A slot with a start X near 511 wraps, so it shows at the left edge. With start X 508, `pix_x` 0 shows pixel 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one slot of the load bank |
| wr_slot | input | 6 | Slot index for the write |
| wr_pal | input | 3 | Palette number of the written sliver |
| wr_prio | input | 2 | Priority of the written sliver |
| wr_x | input | 9 | Start X of the written sliver |
| wr_pattern | input | 32 | Eight 4-bit pixels, pixel 0 in the low nibble |
| line_swap | input | 1 | Exchange banks (horizontal blank strobe) |
| pix_x | input | 9 | Current output pixel X |
| out_color | output | 4 | Winning colour index, 0 when none |
| out_pal | output | 3 | Winning palette |
| out_prio | output | 2 | Winning priority |
| out_valid | output | 1 | An opaque sprite pixel was found |
| out_cmath | output | 1 | Colour math allowed for this pixel |

## Verification
Single slivers are probed just before, at, across and just past their eight-pixel span. This separates the offset arithmetic and the nibble order from an off-by-one in the range test, and a start X of 508 exposes a missing modulo-512 wrap. Stacked slivers pit different priorities against each other, then equal priorities in reversed write order, and then an opaque pixel behind a transparent one. These cases tell a highest-priority pick apart from a first-hit pick, a last-written pick and one that ignores transparency. Writes made while a line is displayed, a swap that follows those writes and a swap with no writes before it show whether the banks are isolated and the valid bits cleared. Slot 33 and an out-of-range index of 40 probe the edges of the slot decode.

// File: rtl/sprite_sel_pkg.sv
package sprite_sel_pkg;

    localparam int SPR_X_W    = 9;
    localparam int SPR_PRIO_W = 2;
    localparam int SPR_PAL_W  = 3;
    localparam int SPR_PIX_W  = 4;
    localparam int SPR_PIX_N  = 8;
    localparam int SPR_PAT_W  = SPR_PIX_W * SPR_PIX_N;
    localparam int SPR_OFF_W  = $clog2(SPR_PIX_N);
    // palettes at or above this value may blend
    localparam int SPR_CMATH_PAL_MIN = 4;

    typedef struct packed {
        logic [SPR_PAL_W-1:0]  pal;
        logic [SPR_PRIO_W-1:0] prio;
        logic [SPR_X_W-1:0]    x;
        logic [SPR_PAT_W-1:0]  pat;
    } spr_slot_t;

    typedef struct packed {
        logic                  hit;
        logic [SPR_PIX_W-1:0]  color;
        logic [SPR_PAL_W-1:0]  pal;
        logic [SPR_PRIO_W-1:0] prio;
    } spr_cand_t;

endpackage

// File: rtl/spr_slot_bank.sv
module spr_slot_bank
    import sprite_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 34,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  spr_slot_t                   wr_data,
    input  logic                        swap,
    output spr_slot_t [NUM_SLOTS-1:0]   disp_slot,
    output logic      [NUM_SLOTS-1:0]   disp_vld
);

    typedef struct packed {
        logic                               disp_sel;
        spr_slot_t [1:0][NUM_SLOTS-1:0]     slot;
        logic      [1:0][NUM_SLOTS-1:0]     vld;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     load_sel;
    logic     wr_ok;

    always_comb begin
        st_d     = st_q;
        load_sel = ~st_q.disp_sel;
        wr_ok    = wr_en && (32'(wr_idx) < NUM_SLOTS);
        if (wr_ok) begin
            st_d.slot[load_sel][wr_idx] = wr_data;
            st_d.vld[load_sel][wr_idx]  = 1'b1;
        end
        if (swap) begin
            st_d.disp_sel          = load_sel;
            st_d.vld[st_q.disp_sel] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_slot = st_q.slot[st_q.disp_sel];
    assign disp_vld  = st_q.vld[st_q.disp_sel];

endmodule

// File: rtl/spr_slot_eval.sv
module spr_slot_eval
    import sprite_sel_pkg::*;
(
    input  logic [SPR_X_W-1:0] pix_x,
    input  spr_slot_t          slot,
    input  logic               vld,
    output spr_cand_t          cand
);

    logic [SPR_X_W-1:0]   offset;
    logic [SPR_OFF_W-1:0] col;
    logic                 in_rng;
    logic [SPR_PIX_W-1:0] color;

    always_comb begin
        offset = pix_x - slot.x;
        in_rng = (offset[SPR_X_W-1:SPR_OFF_W] == '0);
        col    = offset[SPR_OFF_W-1:0];
        color  = slot.pat[SPR_PIX_W*int'(col) +: SPR_PIX_W];
        cand.hit   = vld && in_rng && (color != '0);
        cand.color = color;
        cand.pal   = slot.pal;
        cand.prio  = slot.prio;
    end

endmodule

// File: rtl/spr_prio_pick.sv
module spr_prio_pick
    import sprite_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 34
) (
    input  spr_cand_t [NUM_SLOTS-1:0] cand,
    output spr_cand_t                 win
);

    always_comb begin
        win = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand[i].hit && (!win.hit || (cand[i].prio > win.prio))) begin
                win = cand[i];
            end
        end
    end

endmodule

// File: rtl/spr_line_select.sv
module spr_line_select
    import sprite_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 34,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_slot,
    input  logic [SPR_PAL_W-1:0]   wr_pal,
    input  logic [SPR_PRIO_W-1:0]  wr_prio,
    input  logic [SPR_X_W-1:0]     wr_x,
    input  logic [SPR_PAT_W-1:0]   wr_pattern,
    input  logic                   line_swap,
    input  logic [SPR_X_W-1:0]     pix_x,
    output logic [SPR_PIX_W-1:0]   out_color,
    output logic [SPR_PAL_W-1:0]   out_pal,
    output logic [SPR_PRIO_W-1:0]  out_prio,
    output logic                   out_valid,
    output logic                   out_cmath
);

    typedef struct packed {
        logic [SPR_PIX_W-1:0]  color;
        logic [SPR_PAL_W-1:0]  pal;
        logic [SPR_PRIO_W-1:0] prio;
        logic                  valid;
        logic                  cmath;
    } out_st_t;

    spr_slot_t                  wr_data;
    spr_slot_t [NUM_SLOTS-1:0]  disp_slot;
    logic      [NUM_SLOTS-1:0]  disp_vld;
    spr_cand_t [NUM_SLOTS-1:0]  cand;
    spr_cand_t                  win;
    out_st_t                    out_d, out_q;

    assign wr_data = '{pal: wr_pal, prio: wr_prio, x: wr_x, pat: wr_pattern};

    spr_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_slot),
        .wr_data   (wr_data),
        .swap      (line_swap),
        .disp_slot (disp_slot),
        .disp_vld  (disp_vld)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_eval
        spr_slot_eval u_eval (
            .pix_x (pix_x),
            .slot  (disp_slot[g]),
            .vld   (disp_vld[g]),
            .cand  (cand[g])
        );
    end

    spr_prio_pick #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_pick (
        .cand (cand),
        .win  (win)
    );

    always_comb begin
        out_d = '0;
        if (win.hit) begin
            out_d.color = win.color;
            out_d.pal   = win.pal;
            out_d.prio  = win.prio;
            out_d.valid = 1'b1;
            out_d.cmath = (int'(win.pal) >= SPR_CMATH_PAL_MIN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_color = out_q.color;
    assign out_pal   = out_q.pal;
    assign out_prio  = out_q.prio;
    assign out_valid = out_q.valid;
    assign out_cmath = out_q.cmath;

endmodule

// File: rtl/spr_line_select_chk.sv
module spr_line_select_chk
    import sprite_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 34,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_slot,
    input logic                  line_swap,
    input logic [SPR_PIX_W-1:0]  out_color,
    input logic [SPR_PAL_W-1:0]  out_pal,
    input logic                  out_valid,
    input logic                  out_cmath
);

    logic wr_ok;
    logic wrote_q;
    logic disp_empty_q;

    assign wr_ok = wr_en && (32'(wr_slot) < NUM_SLOTS);

    // tracks whether the displayed bank received any write before its swap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrote_q      <= 1'b0;
            disp_empty_q <= 1'b1;
        end else if (line_swap) begin
            disp_empty_q <= !(wrote_q || wr_ok);
            wrote_q      <= 1'b0;
        end else if (wr_ok) begin
            wrote_q      <= 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !out_cmath && out_color == '0));

    p_valid_opaque_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_color != '0));

    p_cmath_high_pal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_cmath |-> (out_valid && int'(out_pal) >= SPR_CMATH_PAL_MIN));

    p_cmath_low_pal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(out_pal) < SPR_CMATH_PAL_MIN) |-> !out_cmath);

    p_empty_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(disp_empty_q) |-> !out_valid);

endmodule

bind spr_line_select spr_line_select_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/tb_spr_line_select.sv
module tb_spr_line_select;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_slot = '0;
    logic [2:0]  wr_pal = '0;
    logic [1:0]  wr_prio = '0;
    logic [8:0]  wr_x = '0;
    logic [31:0] wr_pattern = '0;
    logic        line_swap = 1'b0;
    logic [8:0]  pix_x = '0;
    logic [3:0]  out_color;
    logic [2:0]  out_pal;
    logic [1:0]  out_prio;
    logic        out_valid;
    logic        out_cmath;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_line_select dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_pal(wr_pal), .wr_prio(wr_prio), .wr_x(wr_x), .wr_pattern(wr_pattern),
        .line_swap(line_swap), .pix_x(pix_x), .out_color(out_color),
        .out_pal(out_pal), .out_prio(out_prio), .out_valid(out_valid),
        .out_cmath(out_cmath)
    );

    task automatic chk(input string tag, input bit v, input logic [3:0] c,
                       input logic [2:0] p, input logic [1:0] pr, input bit cm);
        checks++;
        if ({out_valid, out_color, out_pal, out_prio, out_cmath} !== {v, c, p, pr, cm}) begin
            fails++;
            $display("FAIL %s: got valid=%0b color=%0h pal=%0d prio=%0d cmath=%0b, exp valid=%0b color=%0h pal=%0d prio=%0d cmath=%0b",
                     tag, out_valid, out_color, out_pal, out_prio, out_cmath, v, c, p, pr, cm);
        end
    endtask

    task automatic write_slot(input logic [5:0] s, input logic [2:0] p,
                              input logic [1:0] pr, input logic [8:0] x,
                              input logic [31:0] pat);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = s; wr_pal = p; wr_prio = pr; wr_x = x; wr_pattern = pat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic swap();
        @(negedge clk);
        line_swap = 1'b1;
        @(negedge clk);
        line_swap = 1'b0;
    endtask

    task automatic probe(input logic [8:0] x);
        @(negedge clk);
        pix_x = x;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 during reset", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        probe(9'd0);
        chk("R1 after reset", 0, 0, 0, 0, 0);
        swap();
        probe(9'd0);
        chk("R1 no slot valid", 0, 0, 0, 0, 0);
    endtask

    task automatic t_span();
        write_slot(6'd0, 3'd5, 2'd1, 9'd10, 32'h8765_4321);
        swap();
        probe(9'd9);
        chk("R3 before span", 0, 0, 0, 0, 0);
        probe(9'd10);
        chk("R3 first pixel", 1, 4'h1, 3'd5, 2'd1, 1);
        probe(9'd17);
        chk("R3 last pixel", 1, 4'h8, 3'd5, 2'd1, 1);
        probe(9'd18);
        chk("R3 after span", 0, 0, 0, 0, 0);
        @(negedge clk);
        pix_x = 9'd12;
        #1;
        chk("R2 held before edge", 0, 0, 0, 0, 0);
        @(posedge clk);
        #1;
        chk("R2 after edge", 1, 4'h3, 3'd5, 2'd1, 1);
    endtask

    task automatic t_transparent();
        write_slot(6'd0, 3'd0, 2'd3, 9'd30, 32'h1111_1011);
        write_slot(6'd1, 3'd2, 2'd0, 9'd30, 32'h2222_2222);
        swap();
        probe(9'd32);
        chk("R4 see through transparent", 1, 4'h2, 3'd2, 2'd0, 0);
        probe(9'd30);
        chk("R4 opaque front pixel, R9 pal0", 1, 4'h1, 3'd0, 2'd3, 0);
    endtask

    task automatic t_prio();
        write_slot(6'd5,  3'd1, 2'd1, 9'd100, 32'h3333_3333);
        write_slot(6'd20, 3'd6, 2'd2, 9'd100, 32'h4444_4444);
        write_slot(6'd30, 3'd3, 2'd0, 9'd100, 32'h5555_5555);
        write_slot(6'd31, 3'd7, 2'd3, 9'd100, 32'h0000_0000);
        swap();
        probe(9'd103);
        chk("R5 highest priority", 1, 4'h4, 3'd6, 2'd2, 1);
    endtask

    task automatic t_tie_and_banks();
        write_slot(6'd7, 3'd0, 2'd2, 9'd50, 32'hAAAA_AAAA);
        write_slot(6'd3, 3'd4, 2'd2, 9'd50, 32'h9999_9999);
        swap();
        probe(9'd52);
        chk("R6 tie lower index, R9 pal4", 1, 4'h9, 3'd4, 2'd2, 1);
        write_slot(6'd3, 3'd1, 2'd3, 9'd60, 32'hCCCC_CCCC);
        probe(9'd52);
        chk("R7 load bank hidden", 1, 4'h9, 3'd4, 2'd2, 1);
        probe(9'd61);
        chk("R7 new slot not shown", 0, 0, 0, 0, 0);
        swap();
        probe(9'd52);
        chk("R8 unloaded slot cleared", 0, 0, 0, 0, 0);
        probe(9'd61);
        chk("R8 loaded slot shown", 1, 4'hC, 3'd1, 2'd3, 0);
        swap();
        probe(9'd61);
        chk("R8 empty line", 0, 0, 0, 0, 0);
    endtask

    task automatic t_slot_range();
        write_slot(6'd40, 3'd7, 2'd3, 9'd300, 32'hFFFF_FFFF);
        write_slot(6'd33, 3'd7, 2'd1, 9'd200, 32'hEEEE_EEEE);
        swap();
        probe(9'd300);
        chk("R10 out of range write ignored", 0, 0, 0, 0, 0);
        probe(9'd207);
        chk("R11 slot 33", 1, 4'hE, 3'd7, 2'd1, 1);
    endtask

    task automatic t_wrap();
        write_slot(6'd0, 3'd3, 2'd0, 9'd508, 32'h8765_4321);
        swap();
        probe(9'd0);
        chk("R12 wrap at x0", 1, 4'h5, 3'd3, 2'd0, 0);
        probe(9'd511);
        chk("R12 x511", 1, 4'h4, 3'd3, 2'd0, 0);
        probe(9'd4);
        chk("R12 past wrapped span", 0, 0, 0, 0, 0);
        probe(9'd507);
        chk("R12 before start", 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_span();
        t_transparent();
        t_prio();
        t_tie_and_banks();
        t_slot_range();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got running, exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule